// File: doc/BRIEF.md
# Polled I/O Port Controller

This block sits between a host register bus and a byte-wide device. The host sees four byte registers: one holding the last byte received from the device, one holding the byte to send, a status register and a command register. The host starts a transfer by choosing a direction in the command register and then raising a command-ready bit. The controller answers with a busy flag, moves exactly one byte over a valid/ready channel toward or from the device, and reports the outcome in an error flag. Completion is signalled by busy falling and, if enabled, by a one-cycle interrupt pulse.

The host bus is synchronous. A write strobe with address and data updates a register at the clock edge. Read data is a combinational function of the address and the current register contents. The device side has one outgoing channel (valid, data, ready), one incoming channel (valid, data, ready) and a fault input that aborts the transfer in progress.

Top module: `pio_port_ctrl`

## Requirements
- R1: After reset, all four registers read 0, and `tx_valid`, `rx_ready` and `irq` are low.
- R2: The address map is fixed. Offset 0 is receive data and is read-only. Offset 1 is transmit data. Offset 2 is status: bit0 busy, bit1 error. Offset 3 is command: bit0 write, bit1 read, bit2 command-ready, bit3 interrupt-enable. Unused bits read 0, and host writes to offsets 0 and 2 change nothing.
- R3: A host write that sets command-ready at clock edge k leaves busy reading 0 after edge k. Busy reads 1 after edge k+1.
- R4: For a write command, `tx_valid` rises after edge k+2 with `tx_data` equal to the transmit register. Both hold until the edge where `tx_ready` is high.
- R5: For a read command, `rx_ready` rises after edge k+2. `rx_data` is loaded into the receive register at the edge where `rx_valid` is high.
- R6: At the edge that completes a transfer, command-ready and error clear while busy stays 1. Busy clears at the next edge.
- R7: `dev_fault` high while a transfer is pending ends that transfer. It sets error, leaves the receive register unchanged even if `rx_valid` is high in the same cycle, and follows the same clear order.
- R8: A command with both or neither of write and read set makes no device transfer. It sets error, clears command-ready, and then clears busy.
- R9: While busy or command-ready is set, host writes to the transmit and command registers are ignored.
- R10: If interrupt-enable is set, `irq` is high for exactly the first cycle in which busy reads 0 after a command. Otherwise `irq` stays low.
- R11: Error keeps its value while idle. Only a later command changes it: a successful command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_addr | input | 2 | Host register offset |
| hb_wr | input | 1 | Host write strobe |
| hb_wdata | input | DATA_W | Host write data |
| hb_rdata | output | DATA_W | Host read data for `hb_addr` |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | DATA_W | Outgoing byte |
| tx_ready | input | 1 | Device accepts outgoing byte |
| rx_valid | input | 1 | Device offers incoming byte |
| rx_data | input | DATA_W | Incoming byte |
| rx_ready | output | 1 | Controller accepts incoming byte |
| dev_fault | input | 1 | Device fault for the pending transfer |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after the ordering at the end of a transfer. A design that cleared busy together with command-ready would show status 0 one cycle early. A design that pulsed `irq` at the accepting edge would raise it while busy still reads 1.

It holds the device back for several cycles while the host tries to overwrite the transmit and command registers. A design that let those writes through would send or report the wrong byte.

It raises a fault in the same cycle as a valid incoming byte, which catches a design that still loads the byte. It also issues commands with both and with neither direction set, which catches a design that drives a channel for them. Finally it checks that error survives idle cycles and clears only on a later success.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] OFS_RXD  = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_TXD  = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_STAT = 2'd2;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 2'd3;

    localparam int CMD_WR_BIT = 0;
    localparam int CMD_RD_BIT = 1;
    localparam int CMD_GO_BIT = 2;
    localparam int CMD_IE_BIT = 3;
    localparam int CMD_BITS   = 4;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_DECODE = 2'd1,
        SQ_XFER   = 2'd2,
        SQ_FINISH = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       busy;
        logic       err;
        logic       irq;
    } seq_regs_t;
endpackage

// File: rtl/pio_seq.sv
`timescale 1ns/1ps
module pio_seq
    import pio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic wr_i,
    input  logic rd_i,
    input  logic ie_i,
    input  logic tx_ready_i,
    input  logic rx_valid_i,
    input  logic fault_i,
    output logic busy_o,
    output logic err_o,
    output logic irq_o,
    output logic tx_valid_o,
    output logic rx_ready_o,
    output logic done_o,
    output logic capture_o
);
    seq_regs_t q, d;
    logic      legal_cmd;
    logic      in_xfer;

    always_comb begin
        d         = q;
        d.irq     = 1'b0;
        done_o    = 1'b0;
        capture_o = 1'b0;
        legal_cmd = wr_i ^ rd_i;
        in_xfer   = (q.st == SQ_XFER);
        tx_valid_o = in_xfer && wr_i;
        rx_ready_o = in_xfer && rd_i;
        case (q.st)
            SQ_IDLE: begin
                if (go_i) begin
                    d.busy = 1'b1;
                    d.st   = SQ_DECODE;
                end
            end
            SQ_DECODE: begin
                if (legal_cmd) begin
                    d.st = SQ_XFER;
                end else begin
                    d.err  = 1'b1;
                    done_o = 1'b1;
                    d.st   = SQ_FINISH;
                end
            end
            SQ_XFER: begin
                if (fault_i) begin
                    d.err  = 1'b1;
                    done_o = 1'b1;
                    d.st   = SQ_FINISH;
                end else if ((tx_valid_o && tx_ready_i) ||
                             (rx_ready_o && rx_valid_i)) begin
                    d.err     = 1'b0;
                    done_o    = 1'b1;
                    capture_o = rx_ready_o;
                    d.st      = SQ_FINISH;
                end
            end
            SQ_FINISH: begin
                d.busy = 1'b0;
                d.irq  = ie_i;
                d.st   = SQ_IDLE;
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, busy: 1'b0, err: 1'b0, irq: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy_o = q.busy;
    assign err_o  = q.err;
    assign irq_o  = q.irq;

    // R4
    tx_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o || rx_ready_o) |-> busy_o);
    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i && !fault_i) |=> tx_valid_o);
    // R8
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid_o && rx_ready_o));
    // R10
    irq_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (!busy_o && $past(busy_o)));
    // R7
    fault_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_xfer && fault_i) |=> (err_o && busy_o && !in_xfer));
endmodule

// File: rtl/pio_regs.sv
`timescale 1ns/1ps
module pio_regs
    import pio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] hb_addr_i,
    input  logic              hb_wr_i,
    input  logic [DATA_W-1:0] hb_wdata_i,
    output logic [DATA_W-1:0] hb_rdata_o,
    input  logic              busy_i,
    input  logic              err_i,
    input  logic              done_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic [DATA_W-1:0] txd_o,
    output logic              wr_o,
    output logic              rd_o,
    output logic              go_o,
    output logic              ie_o
);
    localparam int PAD_STAT = DATA_W - 2;
    localparam int PAD_CMD  = DATA_W - CMD_BITS;

    typedef struct packed {
        logic [DATA_W-1:0] rxd;
        logic [DATA_W-1:0] txd;
        logic              wr;
        logic              rd;
        logic              go;
        logic              ie;
    } port_regs_t;

    port_regs_t q, d;
    logic       host_wen;

    always_comb begin
        d        = q;
        host_wen = hb_wr_i && !busy_i && !q.go;
        if (host_wen) begin
            if (hb_addr_i == OFS_TXD) begin
                d.txd = hb_wdata_i;
            end
            if (hb_addr_i == OFS_CMD) begin
                d.wr = hb_wdata_i[CMD_WR_BIT];
                d.rd = hb_wdata_i[CMD_RD_BIT];
                d.go = hb_wdata_i[CMD_GO_BIT];
                d.ie = hb_wdata_i[CMD_IE_BIT];
            end
        end
        if (done_i) begin
            d.go = 1'b0;
        end
        if (capture_i) begin
            d.rxd = rx_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (hb_addr_i)
            OFS_RXD:  hb_rdata_o = q.rxd;
            OFS_TXD:  hb_rdata_o = q.txd;
            OFS_STAT: hb_rdata_o = {{PAD_STAT{1'b0}}, err_i, busy_i};
            default:  hb_rdata_o = {{PAD_CMD{1'b0}}, q.ie, q.go, q.rd, q.wr};
        endcase
    end

    assign txd_o = q.txd;
    assign wr_o  = q.wr;
    assign rd_o  = q.rd;
    assign go_o  = q.go;
    assign ie_o  = q.ie;

    // R9
    txd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && hb_wr_i && hb_addr_i == OFS_TXD) |=> $stable(q.txd));
    // R9
    cmd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && hb_wr_i && hb_addr_i == OFS_CMD) |=> ($stable(q.wr) && $stable(q.rd) && $stable(q.ie)));
    // R7
    rxd_only_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(q.rxd));
endmodule

// File: rtl/pio_port_ctrl.sv
`timescale 1ns/1ps
module pio_port_ctrl
    import pio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        hb_addr,
    input  logic              hb_wr,
    input  logic [DATA_W-1:0] hb_wdata,
    output logic [DATA_W-1:0] hb_rdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    input  logic              dev_fault,
    output logic              irq
);
    logic busy_w, err_w, done_w, capture_w;
    logic wr_w, rd_w, go_w, ie_w;

    pio_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .hb_addr_i  (hb_addr),
        .hb_wr_i    (hb_wr),
        .hb_wdata_i (hb_wdata),
        .hb_rdata_o (hb_rdata),
        .busy_i     (busy_w),
        .err_i      (err_w),
        .done_i     (done_w),
        .capture_i  (capture_w),
        .rx_data_i  (rx_data),
        .txd_o      (tx_data),
        .wr_o       (wr_w),
        .rd_o       (rd_w),
        .go_o       (go_w),
        .ie_o       (ie_w)
    );

    pio_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go_w),
        .wr_i       (wr_w),
        .rd_i       (rd_w),
        .ie_i       (ie_w),
        .tx_ready_i (tx_ready),
        .rx_valid_i (rx_valid),
        .fault_i    (dev_fault),
        .busy_o     (busy_w),
        .err_o      (err_w),
        .irq_o      (irq),
        .tx_valid_o (tx_valid),
        .rx_ready_o (rx_ready),
        .done_o     (done_w),
        .capture_o  (capture_w)
    );

    // R6
    go_before_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_w) |-> !go_w);
    // R3
    busy_on_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_w && !busy_w) |=> busy_w);
    // R4
    tx_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !dev_fault) |=> $stable(tx_data));
endmodule

// File: tb/pio_port_ctrl_tb.sv
`timescale 1ns/1ps
module pio_port_ctrl_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   hb_addr = '0;
    logic         hb_wr = 1'b0;
    logic [W-1:0] hb_wdata = '0;
    logic [W-1:0] hb_rdata;
    logic         tx_valid;
    logic [W-1:0] tx_data;
    logic         tx_ready = 1'b0;
    logic         rx_valid = 1'b0;
    logic [W-1:0] rx_data = '0;
    logic         rx_ready;
    logic         dev_fault = 1'b0;
    logic         irq;

    int checks = 0;
    int failures = 0;
    int xfer_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pio_port_ctrl #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .hb_addr(hb_addr), .hb_wr(hb_wr),
        .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .dev_fault(dev_fault), .irq(irq)
    );

    // Reference model state
    int m_rxd, m_txd, m_wr, m_rd, m_go, m_ie, m_busy, m_err, m_irq, m_phase;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        if (!rst_n) begin
            m_rxd = 0; m_txd = 0; m_wr = 0; m_rd = 0; m_go = 0; m_ie = 0;
            m_busy = 0; m_err = 0; m_irq = 0; m_phase = 0;
        end else begin
            int old_busy, old_go;
            old_busy = m_busy;
            old_go = m_go;
            m_irq = 0;
            case (m_phase)
                0: if (m_go != 0) begin m_busy = 1; m_phase = 1; end
                1: begin
                    if ((m_wr ^ m_rd) != 0) m_phase = 2;
                    else begin m_err = 1; m_go = 0; m_phase = 3; end
                end
                2: begin
                    if (dev_fault) begin m_err = 1; m_go = 0; m_phase = 3; end
                    else if (m_wr != 0 && tx_ready) begin m_err = 0; m_go = 0; m_phase = 3; end
                    else if (m_rd != 0 && rx_valid) begin
                        m_rxd = int'(rx_data); m_err = 0; m_go = 0; m_phase = 3;
                    end
                end
                default: begin m_busy = 0; m_irq = m_ie; m_phase = 0; end
            endcase
            if (hb_wr && old_busy == 0 && old_go == 0) begin
                if (hb_addr == 2'd1) m_txd = int'(hb_wdata);
                if (hb_addr == 2'd3) begin
                    m_wr = int'(hb_wdata[0]); m_rd = int'(hb_wdata[1]);
                    m_go = int'(hb_wdata[2]); m_ie = int'(hb_wdata[3]);
                end
            end
        end
    endtask

    function automatic int model_rdata(input logic [1:0] a);
        case (a)
            2'd0: return m_rxd;
            2'd1: return m_txd;
            2'd2: return m_err * 2 + m_busy;
            default: return m_ie * 8 + m_go * 4 + m_rd * 2 + m_wr;
        endcase
    endfunction

    // Compare on every clock, 1 ns after the edge
    always @(posedge clk) begin
        model_step();
        #1;
        if (rst_n) begin
            check("R4 tx_valid", int'(tx_valid), (m_phase == 2 && m_wr != 0) ? 1 : 0);
            if (tx_valid) check("R4 tx_data", int'(tx_data), m_txd);
            check("R5 rx_ready", int'(rx_ready), (m_phase == 2 && m_rd != 0) ? 1 : 0);
            check("R10 irq", int'(irq), m_irq);
            check("R2 rdata", int'(hb_rdata), model_rdata(hb_addr));
            if (tx_valid || rx_ready) xfer_seen++;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [W-1:0] v);
        @(negedge clk);
        hb_addr = a; hb_wdata = v; hb_wr = 1'b1;
        @(negedge clk);
        hb_wr = 1'b0;
    endtask

    task automatic host_read(input string tag, input logic [1:0] a, input int exp);
        hb_addr = a;
        #1;
        check(tag, int'(hb_rdata), exp);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        host_read("R1 rxd", 2'd0, 0);
        host_read("R1 txd", 2'd1, 0);
        host_read("R1 stat", 2'd2, 0);
        host_read("R1 cmd", 2'd3, 0);
        check("R1 outputs", int'({tx_valid, rx_ready, irq}), 0);

        // R2: writes to read-only offsets do nothing
        host_write(2'd0, 8'h77);
        host_write(2'd2, 8'hFF);
        host_read("R2 rxd ro", 2'd0, 0);
        host_read("R2 stat ro", 2'd2, 0);

        // Write command, interrupt enabled
        host_write(2'd1, 8'hA5);
        host_write(2'd3, 8'h0D);
        host_read("R3 not yet busy", 2'd2, 0);
        step(1);
        host_read("R3 busy", 2'd2, 1);
        step(1);
        check("R4 tx_valid up", int'(tx_valid), 1);
        check("R4 tx_data", int'(tx_data), 8'hA5);
        // R9: writes while busy are ignored
        host_write(2'd1, 8'hFF);
        host_write(2'd3, 8'h00);
        host_read("R9 txd kept", 2'd1, 8'hA5);
        check("R4 tx_valid held", int'(tx_valid), 1);
        tx_ready = 1'b1;
        step(1);
        tx_ready = 1'b0;
        host_read("R6 busy still", 2'd2, 1);
        host_read("R6 go cleared", 2'd3, 8'h09);
        check("R10 no irq yet", int'(irq), 0);
        step(1);
        host_read("R6 busy clear", 2'd2, 0);
        check("R10 irq pulse", int'(irq), 1);
        step(1);
        check("R10 irq one cycle", int'(irq), 0);

        // Read command, interrupt disabled
        host_write(2'd3, 8'h06);
        step(4);
        rx_data = 8'h3C; rx_valid = 1'b1;
        step(1);
        rx_valid = 1'b0;
        step(2);
        host_read("R5 rxd", 2'd0, 8'h3C);
        host_read("R5 stat", 2'd2, 0);

        // Fault during write
        host_write(2'd1, 8'h11);
        host_write(2'd3, 8'h0D);
        step(3);
        dev_fault = 1'b1;
        step(1);
        dev_fault = 1'b0;
        step(2);
        host_read("R7 err", 2'd2, 2);
        step(5);
        host_read("R11 err sticky", 2'd2, 2);

        // Fault on read with a byte offered in the same cycle
        host_write(2'd3, 8'h06);
        step(3);
        dev_fault = 1'b1; rx_valid = 1'b1; rx_data = 8'hEE;
        step(1);
        dev_fault = 1'b0; rx_valid = 1'b0;
        step(2);
        host_read("R7 rxd unchanged", 2'd0, 8'h3C);
        host_read("R7 err", 2'd2, 2);

        // Successful read clears error
        host_write(2'd3, 8'h06);
        step(3);
        rx_data = 8'h5A; rx_valid = 1'b1;
        step(1);
        rx_valid = 1'b0;
        step(2);
        host_read("R11 err cleared", 2'd2, 0);
        host_read("R5 rxd", 2'd0, 8'h5A);

        // Illegal commands
        xfer_seen = 0;
        host_write(2'd3, 8'h04);
        step(4);
        host_read("R8 neither err", 2'd2, 2);
        host_read("R8 go cleared", 2'd3, 0);
        host_write(2'd3, 8'h07);
        step(4);
        host_read("R8 both err", 2'd2, 2);
        check("R8 no transfer", xfer_seen, 0);

        step(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule